// File: doc/BRIEF.md
# Indirect Register Bank with Stepping Window

This unit holds a bank of fifteen 16-bit control registers that a host reaches through only four host addresses. One address holds a 4-bit index. Two addresses are data windows onto the entry that the index selects. The plain window leaves the index alone. The stepping window moves the index to the next entry after every read or write. A host can therefore set the index once and then walk through a run of registers by hitting the stepping window repeatedly. A fourth address holds one control register that is mapped directly and does not use the index.

Reads are combinational. A read returns data in the same cycle that the address is presented. Writes and index changes take effect on the next rising clock edge. Every bank entry, and the direct register, is also driven out as a parallel vector for use by neighbouring logic.

Top module: `idxbank_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, that edge clears the index, every bank entry and the direct register to zero.
- R2: Host address 0 holds the index. A write there loads `host_wdata[3:0]` at the next edge and ignores the upper bits. A read there returns the index zero-extended to 16 bits.
- R3: A read at host address 1, the plain window, returns the entry that the index selects, in the same cycle. It does not change the index.
- R4: A write at host address 1 stores `host_wdata` into the selected entry at the next edge. It leaves every other entry and the index unchanged.
- R5: A read or write at host address 2, the stepping window, uses the index value from before the step for both the read data and the write target. The index then advances by one at the same edge.
- R6: A step from index 0x0E wraps the index to 0x00.
- R7: While the index is 0x0F, a window write changes no entry and a window read returns zero. An access to the stepping window still moves the index to 0x00.
- R8: Host address 3 holds the direct register. A write there loads it at the next edge, and a read returns it. Neither access touches the index or the bank.
- R9: `bank_flat[16*i+15:16*i]` always equals entry i, and `direct_ctl` always equals the direct register. Both update at the edge that completes the write.
- R10: `host_rdata` depends only on `host_addr` and the current state. `host_rd` only decides whether an access to address 2 steps the index. When `host_wr` and `host_rd` are both high, the write is performed and the index steps at most once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 2 | Host location select: 0 index, 1 plain window, 2 stepping window, 3 direct register |
| host_wr | input | 1 | Write strobe for the current cycle |
| host_rd | input | 1 | Read strobe for the current cycle (causes the step at address 2) |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Combinational read data for `host_addr` |
| bank_flat | output | 240 | All bank entries, entry i in bits [16i+15:16i] |
| direct_ctl | output | 16 | Direct control register |

## Verification
Read data is due in the same cycle as the address. The bench therefore samples `host_rdata` 1 ns after it drives inputs on the falling edge, before the next rising edge. Stored values, the parallel outputs and the new index are due one rising edge after the access. The bench compares `bank_flat` and `direct_ctl` 1 ns after that edge. It observes the index through a read of address 0 in a later access. The reference model is updated at the same edge, using the index from before the step.

// File: rtl/idxbank_pkg.sv
package idxbank_pkg;

    // Host location map; the stepping behaviour hangs on WIN_STEP.
    typedef enum logic [1:0] {
        WIN_PTR    = 2'd0,
        WIN_PLAIN  = 2'd1,
        WIN_STEP   = 2'd2,
        WIN_DIRECT = 2'd3
    } win_sel_e;

    localparam int unsigned HOST_AW = 2;

endpackage

// File: rtl/idxbank_ptr.sv
module idxbank_ptr #(
    parameter int unsigned PTR_W   = 4,
    parameter int unsigned ENTRIES = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ptr_wr,
    input  logic [PTR_W-1:0] ptr_wval,
    input  logic             step,
    output logic [PTR_W-1:0] ptr
);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(ENTRIES - 1);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ptr_wr) begin
            st_d.ptr = ptr_wval;
        end else if (step) begin
            // wrap after the last entry, and from any unmapped index
            if (st_q.ptr >= LAST_IDX) begin
                st_d.ptr = '0;
            end else begin
                st_d.ptr = st_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr = st_q.ptr;

endmodule

// File: rtl/idxbank_store.sv
module idxbank_store #(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned PTR_W   = 4,
    parameter int unsigned ENTRIES = 15
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bank_we,
    input  logic [PTR_W-1:0]          bank_idx,
    input  logic                      direct_we,
    input  logic [DATA_W-1:0]         wdata,
    output logic [ENTRIES*DATA_W-1:0] bank_flat,
    output logic [DATA_W-1:0]         direct_q
);
    typedef struct packed {
        logic [ENTRIES-1:0][DATA_W-1:0] bank;
        logic [DATA_W-1:0]              direct;
    } store_state_t;

    store_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < int'(ENTRIES); i++) begin
            if (bank_we && (bank_idx == PTR_W'(i))) begin
                st_d.bank[i] = wdata;
            end
        end
        if (direct_we) begin
            st_d.direct = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bank_flat = st_q.bank;
    assign direct_q  = st_q.direct;

endmodule

// File: rtl/idxbank_rdmux.sv
module idxbank_rdmux
    import idxbank_pkg::*;
#(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned PTR_W   = 4,
    parameter int unsigned ENTRIES = 15
) (
    input  win_sel_e                  sel,
    input  logic [PTR_W-1:0]          ptr,
    input  logic [ENTRIES*DATA_W-1:0] bank_flat,
    input  logic [DATA_W-1:0]         direct_q,
    output logic [DATA_W-1:0]         rdata
);
    logic [DATA_W-1:0] entry [ENTRIES];
    logic [DATA_W-1:0] win_data;

    for (genvar g = 0; g < int'(ENTRIES); g++) begin : g_entry
        assign entry[g] = bank_flat[g*DATA_W +: DATA_W];
    end

    // unmapped index values fall through to zero
    always_comb begin
        win_data = '0;
        for (int i = 0; i < int'(ENTRIES); i++) begin
            if (ptr == PTR_W'(i)) begin
                win_data = entry[i];
            end
        end
    end

    always_comb begin
        unique case (sel)
            WIN_PTR:    rdata = {{(DATA_W-PTR_W){1'b0}}, ptr};
            WIN_PLAIN,
            WIN_STEP:   rdata = win_data;
            WIN_DIRECT: rdata = direct_q;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/idxbank_top.sv
module idxbank_top
    import idxbank_pkg::*;
#(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned PTR_W   = 4,
    parameter int unsigned ENTRIES = 15
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [1:0]                host_addr,
    input  logic                      host_wr,
    input  logic                      host_rd,
    input  logic [DATA_W-1:0]         host_wdata,
    output logic [DATA_W-1:0]         host_rdata,
    output logic [ENTRIES*DATA_W-1:0] bank_flat,
    output logic [DATA_W-1:0]         direct_ctl
);
    localparam logic [PTR_W:0] ENTRY_LIM = (PTR_W+1)'(ENTRIES);

    win_sel_e          sel;
    logic              access;
    logic              ptr_wr;
    logic              step;
    logic              idx_valid;
    logic              bank_we;
    logic              direct_we;
    logic [PTR_W-1:0]  ptr_q;

    always_comb begin
        sel       = win_sel_e'(host_addr);
        access    = host_wr | host_rd;
        ptr_wr    = host_wr && (sel == WIN_PTR);
        step      = access && (sel == WIN_STEP);
        idx_valid = ({1'b0, ptr_q} < ENTRY_LIM);
        bank_we   = host_wr && idx_valid &&
                    ((sel == WIN_PLAIN) || (sel == WIN_STEP));
        direct_we = host_wr && (sel == WIN_DIRECT);
    end

    idxbank_ptr #(
        .PTR_W   (PTR_W),
        .ENTRIES (ENTRIES)
    ) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .ptr_wr   (ptr_wr),
        .ptr_wval (host_wdata[PTR_W-1:0]),
        .step     (step),
        .ptr      (ptr_q)
    );

    idxbank_store #(
        .DATA_W  (DATA_W),
        .PTR_W   (PTR_W),
        .ENTRIES (ENTRIES)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .bank_we   (bank_we),
        .bank_idx  (ptr_q),
        .direct_we (direct_we),
        .wdata     (host_wdata),
        .bank_flat (bank_flat),
        .direct_q  (direct_ctl)
    );

    idxbank_rdmux #(
        .DATA_W  (DATA_W),
        .PTR_W   (PTR_W),
        .ENTRIES (ENTRIES)
    ) u_rdmux (
        .sel       (sel),
        .ptr       (ptr_q),
        .bank_flat (bank_flat),
        .direct_q  (direct_ctl),
        .rdata     (host_rdata)
    );

endmodule

// File: rtl/idxbank_chk.sv
module idxbank_chk #(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned PTR_W   = 4,
    parameter int unsigned ENTRIES = 15
) (
    input logic                      clk,
    input logic                      rst,
    input logic [1:0]                host_addr,
    input logic                      host_wr,
    input logic                      host_rd,
    input logic [DATA_W-1:0]         host_wdata,
    input logic [DATA_W-1:0]         host_rdata,
    input logic [ENTRIES*DATA_W-1:0] bank_flat,
    input logic [DATA_W-1:0]         direct_ctl,
    input logic [PTR_W-1:0]          ptr_q
);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(ENTRIES - 1);
    localparam logic [PTR_W-1:0] ALL_ONES = '1;

    logic acc;
    assign acc = host_wr | host_rd;

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (ptr_q == '0) && (direct_ctl == '0) && (bank_flat == '0));

    assert_ptr_load_R2: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == 2'd0) |=> ptr_q == $past(host_wdata[PTR_W-1:0]));

    assert_plain_keeps_ptr_R3: assert property (@(posedge clk) disable iff (rst)
        (acc && host_addr == 2'd1) |=> $stable(ptr_q));

    assert_step_advance_R5: assert property (@(posedge clk) disable iff (rst)
        (acc && host_addr == 2'd2 && ptr_q < LAST_IDX) |=> ptr_q == $past(ptr_q) + 1'b1);

    assert_step_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (acc && host_addr == 2'd2 && ptr_q == LAST_IDX) |=> ptr_q == '0);

    assert_unmapped_write_R7: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr[1] != host_addr[0] && ptr_q == ALL_ONES) |=> $stable(bank_flat));

    assert_unmapped_read_R7: assert property (@(posedge clk) disable iff (rst)
        (host_addr[1] != host_addr[0] && ptr_q == ALL_ONES) |-> host_rdata == '0);

    assert_direct_load_R8: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == 2'd3) |=> direct_ctl == $past(host_wdata) && $stable(ptr_q));

    assert_direct_read_R10: assert property (@(posedge clk) disable iff (rst)
        (host_addr == 2'd3) |-> host_rdata == direct_ctl);

endmodule

bind idxbank_top idxbank_chk #(
    .DATA_W  (DATA_W),
    .PTR_W   (PTR_W),
    .ENTRIES (ENTRIES)
) u_chk (.*);

// File: tb/idxbank_top_tb.sv
module idxbank_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int NE = 15;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [1:0]         host_addr = '0;
    logic               host_wr = 1'b0;
    logic               host_rd = 1'b0;
    logic [DW-1:0]      host_wdata = '0;
    logic [DW-1:0]      host_rdata;
    logic [NE*DW-1:0]   bank_flat;
    logic [DW-1:0]      direct_ctl;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [DW-1:0] m_bank [NE];
    logic [3:0]    m_ptr;
    logic [DW-1:0] m_direct;

    always #(CLK_PERIOD/2) clk = ~clk;

    idxbank_top u_dut (
        .clk        (clk),
        .rst        (rst),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .bank_flat  (bank_flat),
        .direct_ctl (direct_ctl)
    );

    function automatic logic [DW-1:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return {12'h000, m_ptr};
            2'd3:    return m_direct;
            default: return (m_ptr < 4'(NE)) ? m_bank[m_ptr] : '0;
        endcase
    endfunction

    function automatic logic [NE*DW-1:0] exp_flat();
        logic [NE*DW-1:0] v;
        for (int i = 0; i < NE; i++) v[i*DW +: DW] = m_bank[i];
        return v;
    endfunction

    function automatic string req_of(input logic [1:0] a);
        case (a)
            2'd0:    return "R2";
            2'd1:    return "R3";
            2'd2:    return "R5";
            default: return "R8";
        endcase
    endfunction

    task automatic check16(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_outs(input string req);
        n_checks++;
        if (bank_flat !== exp_flat() || direct_ctl !== m_direct) begin
            n_fail++;
            $display("FAIL %s: actual bank %h direct %h expected bank %h direct %h",
                     req, bank_flat, direct_ctl, exp_flat(), m_direct);
        end
    endtask

    // one host cycle: same-cycle read check, then state checked after the edge
    task automatic op(input logic [1:0] a, input logic wr, input logic rd,
                      input logic [DW-1:0] d, input string req);
        @(negedge clk);
        host_addr = a; host_wr = wr; host_rd = rd; host_wdata = d;
        #1;
        check16({req, "/R10 read"}, host_rdata, exp_read(a));
        @(posedge clk);
        if (wr) begin
            case (a)
                2'd0: m_ptr = d[3:0];
                2'd3: m_direct = d;
                default: if (m_ptr < 4'(NE)) m_bank[m_ptr] = d;
            endcase
        end
        if ((wr || rd) && a == 2'd2) m_ptr = (m_ptr >= 4'(NE-1)) ? 4'h0 : m_ptr + 4'h1;
        #1;
        check_outs({req, "/R9 outputs"});
        host_wr = 1'b0; host_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hang, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        for (int i = 0; i < NE; i++) m_bank[i] = '0;
        m_ptr = '0; m_direct = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state
        #1;
        check_outs("R1");
        op(2'd0, 1'b0, 1'b1, '0, "R1");

        // R2: pointer write drops upper bits
        op(2'd0, 1'b1, 1'b0, 16'hFFF5, "R2");
        op(2'd0, 1'b0, 1'b1, '0, "R2");
        // R4: plain write, pointer unchanged
        op(2'd1, 1'b1, 1'b0, 16'h5A5A, "R4");
        op(2'd0, 1'b0, 1'b1, '0, "R4");
        // R5/R6: stepping run across the wrap
        op(2'd0, 1'b1, 1'b0, 16'h000D, "R6");
        op(2'd2, 1'b1, 1'b0, 16'hAAAA, "R5");
        op(2'd2, 1'b1, 1'b0, 16'hBBBB, "R6");
        op(2'd0, 1'b0, 1'b1, '0, "R6");
        op(2'd2, 1'b0, 1'b1, '0, "R5");
        // R7: unmapped index
        op(2'd0, 1'b1, 1'b0, 16'h000F, "R7");
        op(2'd1, 1'b1, 1'b0, 16'h1234, "R7");
        op(2'd1, 1'b0, 1'b1, '0, "R7");
        op(2'd2, 1'b1, 1'b1, 16'h4321, "R7");
        op(2'd0, 1'b0, 1'b1, '0, "R7");
        // R8: direct register
        op(2'd3, 1'b1, 1'b0, 16'hC0DE, "R8");
        op(2'd3, 1'b0, 1'b1, '0, "R8");
        op(2'd0, 1'b0, 1'b1, '0, "R8");
        // R10: no strobes at the stepping window, no step
        op(2'd2, 1'b0, 1'b0, 16'hFFFF, "R10");
        op(2'd0, 1'b0, 1'b0, '0, "R10");

        for (int k = 0; k < 800; k++) begin
            logic [1:0] a;
            logic [DW-1:0] d;
            a = 2'($urandom_range(0, 3));
            d = 16'($urandom);
            op(a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), d, req_of(a));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule